// File: doc/BRIEF.md
# Instruction Queue Resize Controller

This controller decides, one partition at a time, when an out-of-order instruction queue should shrink or grow its active window. Time is cut into quanta of a configurable number of cycles. During each quantum the controller counts committed instructions that came from the youngest active partition of the queue. If that partition contributed fewer commits than a configurable threshold, it cannot be doing useful work, so the controller asks the queue to give up one partition.

Because a threshold rule can only ever shrink, the controller also forces a grow of one partition every fifth quantum, whatever the count was. The measurement taken during the quantum after a forced grow then decides whether the extra partition stays or is removed again. The queue receives the decisions as single-cycle pulses. It enforces its own minimum and maximum size, and the controller applies no bound of its own.

Quantum length and threshold come from configuration inputs. They are captured at quantum boundaries, so software may change them at any time without breaking a running measurement.

Top module: `iq_resize_ctrl`

## Requirements
- R1: A commit lane adds one to the quantum's count only when both its valid bit and its youngest-partition bit are 1. A young bit on an invalid lane is ignored. Up to LANES (default 4) commits are added per cycle.
- R2: In the cycle after a quantum's last cycle, shrink_o pulses if the quantum's count is below the threshold in force for that quantum. The count includes commits made in the last cycle itself.
- R3: When the count equals or exceeds the threshold, no shrink is issued.
- R4: grow_o pulses after every fifth quantum boundary (quanta 5, 10, 15, and so on, counted from reset), regardless of the count.
- R5: When a forced grow and a shrink fall on the same boundary, only grow_o pulses. grow_o and shrink_o are never high together.
- R6: Each pulse lasts one cycle per boundary. Both outputs are low in every cycle that does not directly follow a quantum boundary.
- R7: The per-quantum count saturates at 2^CNT_W-1 (default 255) instead of wrapping.
- R8: The first quantum after reset has the length present on qlen_i in the first cycle after reset. Every later quantum has the length present on qlen_i in the last cycle of the quantum before it. A length of 0 acts as 1.
- R9: The threshold is captured with the same timing as the length. A change to thr_i in the middle of a quantum affects only later quanta.
- R10: While in reset and directly after it, grow_o and shrink_o are 0.
- R11: After a forced grow, the next quantum's count alone decides whether a shrink follows (a shrink if below the threshold, none otherwise).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_vld_i | input | LANES | Per-lane commit valid |
| commit_young_i | input | LANES | Per-lane flag: instruction came from the youngest active partition |
| qlen_i | input | QLEN_W | Quantum length in cycles (0 acts as 1) |
| thr_i | input | CNT_W | Shrink threshold on the young-commit count |
| grow_o | output | 1 | One-cycle request to enable one more partition |
| shrink_o | output | 1 | One-cycle request to disable the youngest partition |

## Verification
On every cycle the assertions check the following: the two pulses never overlap, grow never lasts two cycles, and every pulse follows a boundary cycle. They also check that a grow leaves the quantum index at zero, that a saturated count stays at its ceiling until the boundary, and that the timer keeps running between boundaries. Only the bench scenarios show that the decisions are right. These cover the counts that are compared (invalid lanes, commits in the boundary cycle, the equal-to-threshold edge, saturation), the grow-over-shrink priority, and the confirm-or-undo sequence after a grow. They also show that configuration changes made in the middle of a quantum take effect only at the next quantum.

// File: rtl/iq_rsz_pkg.sv
package iq_rsz_pkg;
  typedef enum logic [1:0] {
    RSZ_HOLD   = 2'd0,
    RSZ_GROW   = 2'd1,
    RSZ_SHRINK = 2'd2
  } rsz_act_e;
endpackage

// File: rtl/rsz_quantum_timer.sv
module rsz_quantum_timer #(
  parameter int unsigned QLEN_W = 12,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [QLEN_W-1:0] qlen_i,
  input  logic [CNT_W-1:0]  thr_i,
  output logic              q_end_o,
  output logic [CNT_W-1:0]  thr_cur_o,
  output logic [QLEN_W-1:0] tmr_o
);
  logic              pend_q;
  logic [QLEN_W-1:0] len_q, tmr_q, len_eff;
  logic [CNT_W-1:0]  thr_q;

  // first quantum after reset uses the live inputs
  assign len_eff   = pend_q ? qlen_i : len_q;
  assign thr_cur_o = pend_q ? thr_i  : thr_q;
  assign q_end_o   = ({1'b0, tmr_q} + (QLEN_W+1)'(1)) >= {1'b0, len_eff};
  assign tmr_o     = tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
      len_q  <= '0;
      thr_q  <= '0;
      tmr_q  <= '0;
    end else begin
      pend_q <= 1'b0;
      if (q_end_o) begin
        tmr_q <= '0;
        len_q <= qlen_i;
        thr_q <= thr_i;
      end else begin
        tmr_q <= tmr_q + QLEN_W'(1);
        if (pend_q) begin
          len_q <= qlen_i;
          thr_q <= thr_i;
        end
      end
    end
  end
endmodule

// File: rtl/rsz_commit_acc.sv
module rsz_commit_acc #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] vld_i,
  input  logic [LANES-1:0] young_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned INC_W = $clog2(LANES + 1);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [INC_W-1:0] inc;
  logic [CNT_W:0]   sum;

  always_comb begin
    inc = '0;
    for (int i = 0; i < LANES; i++) inc = inc + INC_W'(vld_i[i] & young_i[i]);
  end

  assign sum     = {1'b0, cnt_q} + (CNT_W+1)'(inc);
  assign total_o = (sum > CNT_MAX) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= total_o;
  end
endmodule

// File: rtl/rsz_grow_sched.sv
module rsz_grow_sched #(
  parameter int unsigned PERIOD = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic q_end_i,
  output logic due_o,
  output logic [((PERIOD > 1) ? $clog2(PERIOD) : 1)-1:0] idx_o
);
  localparam int unsigned IDX_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PERIOD - 1);

  logic [IDX_W-1:0] idx_q;

  assign due_o = q_end_i && (idx_q == LAST);
  assign idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (due_o)   idx_q <= '0;
    else if (q_end_i) idx_q <= idx_q + IDX_W'(1);
  end
endmodule

// File: rtl/iq_resize_ctrl.sv
module iq_resize_ctrl #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned QLEN_W = 12,
  parameter int unsigned PERIOD = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  commit_vld_i,
  input  logic [LANES-1:0]  commit_young_i,
  input  logic [QLEN_W-1:0] qlen_i,
  input  logic [CNT_W-1:0]  thr_i,
  output logic              grow_o,
  output logic              shrink_o
);
  import iq_rsz_pkg::*;
  localparam int unsigned IDX_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic              q_end, grow_due;
  logic [CNT_W-1:0]  thr_cur, total, acc_cnt;
  logic [QLEN_W-1:0] tmr_cnt;
  logic [IDX_W-1:0]  grow_idx;
  rsz_act_e          act;
  logic              grow_q, shrink_q;

  rsz_quantum_timer #(.QLEN_W(QLEN_W), .CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .qlen_i, .thr_i,
    .q_end_o(q_end), .thr_cur_o(thr_cur), .tmr_o(tmr_cnt)
  );

  rsz_commit_acc #(.LANES(LANES), .CNT_W(CNT_W)) u_acc (
    .clk_i, .rst_ni, .vld_i(commit_vld_i), .young_i(commit_young_i),
    .clr_i(q_end), .total_o(total), .cnt_o(acc_cnt)
  );

  rsz_grow_sched #(.PERIOD(PERIOD)) u_sched (
    .clk_i, .rst_ni, .q_end_i(q_end), .due_o(grow_due), .idx_o(grow_idx)
  );

  // forced grow wins over a threshold shrink
  always_comb begin
    act = RSZ_HOLD;
    if (q_end) begin
      if (grow_due)             act = RSZ_GROW;
      else if (total < thr_cur) act = RSZ_SHRINK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grow_q   <= 1'b0;
      shrink_q <= 1'b0;
    end else begin
      grow_q   <= (act == RSZ_GROW);
      shrink_q <= (act == RSZ_SHRINK);
    end
  end

  assign grow_o   = grow_q;
  assign shrink_o = shrink_q;
endmodule

// File: rtl/iq_resize_ctrl_chk.sv
module iq_resize_ctrl_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned QLEN_W = 12,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              grow_o,
  input logic              shrink_o,
  input logic              q_end,
  input logic [CNT_W-1:0]  acc_cnt,
  input logic [QLEN_W-1:0] tmr_cnt,
  input logic [IDX_W-1:0]  grow_idx
);
  logic bnd_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bnd_d <= 1'b0;
    else         bnd_d <= q_end;
  end

  // R5
  excl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grow_o && shrink_o));

  // R6
  grow_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grow_o |=> !grow_o);

  // R6
  pulse_after_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grow_o || shrink_o) |-> bnd_d);

  // R4
  grow_wraps_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grow_o |-> (grow_idx == '0));

  // R7
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_end && (acc_cnt == {CNT_W{1'b1}})) |=> (acc_cnt == {CNT_W{1'b1}}));

  // R8
  tmr_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_end |=> (tmr_cnt != '0));
endmodule

bind iq_resize_ctrl iq_resize_ctrl_chk #(
  .CNT_W(CNT_W), .QLEN_W(QLEN_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .grow_o(grow_o), .shrink_o(shrink_o),
  .q_end(q_end), .acc_cnt(acc_cnt), .tmr_cnt(tmr_cnt), .grow_idx(grow_idx)
);

// File: tb/iq_resize_ctrl_bench.sv
module iq_resize_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int CNT_W = 8;
  localparam int QLEN_W = 12;
  localparam int CNT_MAX = 255;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [LANES-1:0]  vld = '0, yng = '0;
  logic [QLEN_W-1:0] qlen = '0;
  logic [CNT_W-1:0]  thr = '0;
  logic              grow, shrink;

  int total = 0, bad = 0, qn = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_resize_ctrl u_iq_resize_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .commit_vld_i(vld), .commit_young_i(yng),
    .qlen_i(qlen), .thr_i(thr), .grow_o(grow), .shrink_o(shrink)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int pc(input logic [LANES-1:0] m);
    int n = 0;
    for (int i = 0; i < LANES; i++) n += m[i];
    return n;
  endfunction

  // R10
  task automatic do_reset(input int first_len, input int first_thr);
    rst_ni = 1'b0; vld = '0; yng = '0;
    qlen = QLEN_W'(first_len); thr = CNT_W'(first_thr);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 grow in reset", grow, 0);
    chk("R10 shrink in reset", shrink, 0);
    rst_ni = 1'b1;
    qn = 0;
  endtask

  // one quantum; bench sits at a negedge on entry and exit
  task automatic quantum(input int len, input int th, input logic [LANES-1:0] v,
                         input logic [LANES-1:0] y, input logic [LANES-1:0] y_last,
                         input int nlen, input int nth, input string req);
    int eff = (len == 0) ? 1 : len;
    int cnt, eg, es;
    bit quiet = 1;
    qn++;
    for (int i = 0; i < eff; i++) begin
      if (i > 0 && (grow || shrink)) quiet = 0;
      vld = v;
      yng = (i == eff - 1) ? y_last : y;
      if (i == ((eff > 1) ? 1 : 0)) begin
        qlen = QLEN_W'(nlen); thr = CNT_W'(nth);
      end
      @(posedge clk);
      @(negedge clk);
    end
    cnt = (eff - 1) * pc(v & y) + pc(v & y_last);
    if (cnt > CNT_MAX) cnt = CNT_MAX;
    eg = (qn % 5 == 0) ? 1 : 0;
    es = (!eg && cnt < th) ? 1 : 0;
    if (eff > 1) chk({req, " R6 quiet inside quantum"}, quiet, 1);
    chk({req, " grow"}, grow, eg);
    chk({req, " shrink"}, shrink, es);
  endtask

  task automatic t_threshold;
    do_reset(8, 10);
    quantum(8, 10, 4'hF, 4'h1, 4'h1, 8, 8, "R2 R9 8<10");
    quantum(8, 8, 4'hF, 4'h1, 4'h1, 4, 9, "R3 equal");
    quantum(4, 9, 4'h5, 4'hF, 4'hF, 6, 4, "R1 invalid lanes");
    quantum(6, 4, 4'hF, 4'h0, 4'hF, 8, 10, "R2 last-cycle commits");
  endtask

  task automatic t_grow_cycle;
    quantum(8, 10, 4'hF, 4'h0, 4'h0, 8, 3, "R4 R5 forced grow");
    quantum(8, 3, 4'hF, 4'h0, 4'h0, 8, 3, "R11 undo after grow");
    quantum(8, 3, 4'hF, 4'h1, 4'h1, 100, 255, "R11 keep");
  endtask

  task automatic t_saturate;
    quantum(100, 255, 4'hF, 4'hF, 4'hF, 6, 10, "R7 saturate");
  endtask

  task automatic t_config;
    quantum(6, 10, 4'hF, 4'h1, 4'h1, 3, 1, "R8 R9 mid change");
    quantum(3, 1, 4'hF, 4'h1, 4'h1, 3, 1, "R4 R8 grow at 10");
    quantum(3, 1, 4'hF, 4'h1, 4'h1, 0, 2, "R8 new length");
    quantum(0, 2, 4'hF, 4'h1, 4'h1, 0, 2, "R8 zero length");
    quantum(0, 2, 4'hF, 4'hF, 4'hF, 0, 5, "R3 len1");
    quantum(0, 5, 4'hF, 4'hF, 4'hF, 0, 5, "R2 len1");
    quantum(0, 5, 4'hF, 4'hF, 4'hF, 0, 5, "R5 grow beats shrink");
    quantum(0, 5, 4'hF, 4'hF, 4'hF, 0, 5, "R11 shrink after grow");
  endtask

  initial begin
    @(negedge clk);
    t_threshold();
    t_grow_cycle();
    t_saturate();
    t_config();
    // R6: pulses drop after one cycle
    vld = '0; yng = '0; qlen = 12'd50;
    @(posedge clk); @(negedge clk);
    chk("R6 grow low after pulse", grow, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule